// File: doc/BRIEF.md
# Task-Slot Engine Clock Enable

This block produces the clock enable for a processor core's execution engine. A repeating table of sixteen time slots assigns each slot to one of four hardware tasks. A four-bit mask can mark any task as clock-off. In a slot owned by a masked task, the engine gets no clock for the whole slot. A programmable divider sets how many system clocks one slot lasts. The engine therefore runs at n/16 of the divided rate, where n is the number of slots owned by unmasked tasks.

Waits are handled apart from the gating. A free-running system-clock counter and an armed target comparator raise a wake pulse in the exact system clock the target is reached. This holds however slowly the engine is being clocked, and even when every task is masked off.

Configuration writes to the slot table, mask and divider are held in a staging copy. They take effect only when the slot pointer wraps back to slot 0, so one rotation never mixes old and new settings.

Top module: `slot_clk_gate`

## Requirements
- R1: After reset every slot belongs to task 0, no task is masked, the divider is 0 and the slot pointer is 0. From the first cycle, `eng_clk_en` is 1 on every system clock, `task_id` is 0 and `wait_done` is 0.
- R2: The owner of slot i is `cfg_slot_map[2i+1:2i]`. `task_id` shows the owner of the current slot and changes in the same cycle the slot pointer advances.
- R3: Bit t of `cfg_off_mask` set means task t is clock-off. Throughout a slot owned by such a task, `eng_clk_en` stays 0 unless a wake pulse is present.
- R4: With divider 0, `eng_clk_en` is high in exactly n of every 16 consecutive aligned cycles, where n counts the slots whose owner is unmasked.
- R5: Divider value D makes a slot last D+1 system clocks. The slot pointer advances (15 wraps to 0) only on the last cycle of the slot. `eng_clk_en` can be high only in that cycle, and only if the slot is unmasked.
- R6: A `cfg_wr` pulse stages all three settings. They become active together at the next advance from slot 15 to slot 0. Until then the old settings govern enable and `task_id`.
- R7: A 32-bit time counter starts at 0 after reset and increments on every system clock whatever the gating. Once armed by `wait_arm`, `wait_done` is high for exactly the one cycle in which the counter equals the captured target.
- R8: With every task masked, `eng_clk_en` stays 0, except that a `wait_done` pulse forces it to 1 for that cycle.
- R9: Wait resolution stays at one system clock when the divider is non-zero. The wake pulse may land on a cycle that is not a slot boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Stage the three configuration inputs |
| cfg_slot_map | input | 32 | Slot owner table, 2 bits per slot |
| cfg_off_mask | input | 4 | Per-task clock-off flags |
| cfg_divider | input | 8 | Slot length minus one, in system clocks |
| wait_arm | input | 1 | Arm the wait comparator with `wait_target` |
| wait_target | input | 32 | Time counter value to wake on |
| eng_clk_en | output | 1 | Execution-engine clock enable |
| task_id | output | 2 | Owner of the current slot |
| wait_done | output | 1 | One-cycle wake pulse |

## Verification
The enable, `task_id` and `wait_done` are combinational from registers. Each result is therefore due in the cycle after the edge that moves the pointer, the divider count or the time counter. The bench keeps its own count of edges since reset and turns every expectation into a cycle index. The enable is due when the index modulo D+1 equals D. The pointer equals the index divided by D+1, modulo 16. The wake pulse is due when the index equals the target.

Configuration writes are issued at a fixed offset inside a rotation. This puts the first cycle under the new settings at a known multiple of the rotation length. All outputs are sampled on the falling edge, half a cycle after the registers settle.

// File: rtl/slot_gate_pkg.sv
package slot_gate_pkg;
  localparam int DEF_SLOTS  = 16;
  localparam int DEF_TASKS  = 4;
  localparam int DEF_DIV_W  = 8;
  localparam int DEF_TIME_W = 32;
endpackage

// File: rtl/slot_rate_div.sv
module slot_rate_div #(
  parameter int DIV_W = slot_gate_pkg::DEF_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  function automatic logic at_slot_end(input logic [DIV_W-1:0] c,
                                       input logic [DIV_W-1:0] d);
    return c == d;
  endfunction

  assign tick = at_slot_end(cnt_q, div_val);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (div_val == '0 || !tick));
endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer #(
  parameter int SLOTS = slot_gate_pkg::DEF_SLOTS,
  parameter int TASKS = slot_gate_pkg::DEF_TASKS,
  parameter int DIV_W = slot_gate_pkg::DEF_DIV_W,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int TASK_W = $clog2(TASKS),
  localparam int MAP_W  = SLOTS * TASK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cfg_wr,
  input  logic [MAP_W-1:0]  cfg_map,
  input  logic [TASKS-1:0]  cfg_off,
  input  logic [DIV_W-1:0]  cfg_div,
  output logic [SLOT_W-1:0] ptr,
  output logic [TASKS-1:0]  off_act,
  output logic [DIV_W-1:0]  div_act,
  output logic [TASK_W-1:0] task_id
);
  logic [MAP_W-1:0]  map_act;
  logic [MAP_W-1:0]  map_stg;
  logic [TASKS-1:0]  off_stg;
  logic [DIV_W-1:0]  div_stg;
  logic              pend_q;
  logic              wrap;
  logic [TASK_W-1:0] owner_w [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_owner
    assign owner_w[s] = map_act[s*TASK_W +: TASK_W];
  end

  function automatic logic is_last_slot(input logic [SLOT_W-1:0] p);
    return p == SLOT_W'(SLOTS - 1);
  endfunction

  assign wrap    = tick && is_last_slot(ptr);
  assign task_id = owner_w[ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      map_act <= '0;
      off_act <= '0;
      div_act <= '0;
      map_stg <= '0;
      off_stg <= '0;
      div_stg <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (tick) ptr <= ptr + 1'b1;
      if (wrap && pend_q) begin
        map_act <= map_stg;
        off_act <= off_stg;
        div_act <= div_stg;
      end
      if (cfg_wr) begin
        map_stg <= cfg_map;
        off_stg <= cfg_off;
        div_stg <= cfg_div;
        pend_q  <= 1'b1;
      end else if (wrap) begin
        pend_q  <= 1'b0;
      end
    end
  end

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ptr));
  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ptr == SLOT_W'($past(ptr) + 1'b1));
  // R6
  cfg_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(map_act) || !$stable(off_act) || !$stable(div_act)) |-> ptr == '0);
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int TIME_W = slot_gate_pkg::DEF_TIME_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wait_arm,
  input  logic [TIME_W-1:0] wait_target,
  output logic              wait_done
);
  logic [TIME_W-1:0] sys_cnt;
  logic [TIME_W-1:0] tgt_q;
  logic              armed_q;

  function automatic logic hit(input logic [TIME_W-1:0] now,
                               input logic [TIME_W-1:0] tgt);
    return now == tgt;
  endfunction

  assign wait_done = armed_q && hit(sys_cnt, tgt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sys_cnt <= '0;
      tgt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      sys_cnt <= sys_cnt + 1'b1;
      if (wait_arm) begin
        tgt_q   <= wait_target;
        armed_q <= 1'b1;
      end else if (wait_done) begin
        armed_q <= 1'b0;
      end
    end
  end

  // R7
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sys_cnt == TIME_W'($past(sys_cnt) + 1'b1));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_done && !wait_arm) |=> !wait_done);
endmodule

// File: rtl/slot_clk_gate.sv
module slot_clk_gate #(
  parameter int SLOTS  = slot_gate_pkg::DEF_SLOTS,
  parameter int TASKS  = slot_gate_pkg::DEF_TASKS,
  parameter int DIV_W  = slot_gate_pkg::DEF_DIV_W,
  parameter int TIME_W = slot_gate_pkg::DEF_TIME_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_wr,
  input  logic [SLOTS*$clog2(TASKS)-1:0]   cfg_slot_map,
  input  logic [TASKS-1:0]                 cfg_off_mask,
  input  logic [DIV_W-1:0]                 cfg_divider,
  input  logic                             wait_arm,
  input  logic [TIME_W-1:0]                wait_target,
  output logic                             eng_clk_en,
  output logic [$clog2(TASKS)-1:0]         task_id,
  output logic                             wait_done
);
  localparam int SLOT_W = $clog2(SLOTS);

  logic              tick;
  logic [SLOT_W-1:0] ptr;
  logic [TASKS-1:0]  off_act;
  logic [DIV_W-1:0]  div_act;
  logic              slot_live;

  slot_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div_val(div_act), .tick(tick)
  );

  slot_sequencer #(.SLOTS(SLOTS), .TASKS(TASKS), .DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfg_wr(cfg_wr), .cfg_map(cfg_slot_map), .cfg_off(cfg_off_mask),
    .cfg_div(cfg_divider), .ptr(ptr), .off_act(off_act),
    .div_act(div_act), .task_id(task_id)
  );

  wait_timer #(.TIME_W(TIME_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .wait_arm(wait_arm),
    .wait_target(wait_target), .wait_done(wait_done)
  );

  assign slot_live  = !off_act[task_id];
  assign eng_clk_en = (tick && slot_live) || wait_done;

  // R3
  gated_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_clk_en && !wait_done) |-> !off_act[task_id]);
  // R2
  task_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(task_id) |-> $past(tick));
  // R8
  all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&off_act && !wait_done) |-> !eng_clk_en);
endmodule

// File: tb/slot_clk_gate_test.sv
module slot_clk_gate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_slot_map = '0;
  logic [3:0]  cfg_off_mask = '0;
  logic [7:0]  cfg_divider = '0;
  logic        wait_arm = 1'b0;
  logic [31:0] wait_target = '0;
  logic        eng_clk_en;
  logic [1:0]  task_id;
  logic        wait_done;

  int checks = 0;
  int errors = 0;
  int unsigned bc;
  logic [31:0] cur_map = '0;
  logic [3:0]  cur_off = '0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) bc <= 0;
    else        bc <= bc + 1;
  end

  slot_clk_gate uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_slot_map(cfg_slot_map),
    .cfg_off_mask(cfg_off_mask), .cfg_divider(cfg_divider),
    .wait_arm(wait_arm), .wait_target(wait_target),
    .eng_clk_en(eng_clk_en), .task_id(task_id), .wait_done(wait_done)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h",
               req, what, bc, act, exp);
    end
  endtask

  function automatic logic [1:0] own(input logic [31:0] m, input int s);
    return m[2*s +: 2];
  endfunction

  task automatic align_to(input int phase);
    @(negedge clk);
    while (bc % 16 != phase) @(negedge clk);
  endtask

  task automatic stage(input logic [31:0] m, input logic [3:0] o,
                       input logic [7:0] d);
    cfg_slot_map = m; cfg_off_mask = o; cfg_divider = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: first cycle out of reset, bc == 0
    chk("R1", "enable", 32'(eng_clk_en), 32'd1);
    chk("R1", "task_id", 32'(task_id), 32'd0);
    chk("R1", "wait_done", 32'(wait_done), 32'd0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R1", "enable", 32'(eng_clk_en), 32'd1);
    end
  endtask

  // divider 0: slot index equals bc modulo 16
  task automatic t_rate(input logic [31:0] m, input logic [3:0] o, input int n);
    int cnt = 0;
    align_to(3);
    stage(m, o, 8'd0);
    while (bc % 16 != 0) begin
      // R6: old settings still in force before the wrap
      chk("R6", "old enable", 32'(eng_clk_en),
          32'(!cur_off[own(cur_map, bc % 16)]));
      chk("R6", "old task", 32'(task_id), 32'(own(cur_map, bc % 16)));
      @(negedge clk);
    end
    for (int k = 0; k < 16; k++) begin
      // R2 R3
      chk("R2", "task_id", 32'(task_id), 32'(own(m, k)));
      chk("R3", "enable", 32'(eng_clk_en), 32'(!o[own(m, k)]));
      cnt += int'(eng_clk_en);
      @(negedge clk);
    end
    // R4
    chk("R4", "enables per rotation", 32'(cnt), 32'(n));
    cur_map = m; cur_off = o;
  endtask

  task automatic t_all_off();
    int unsigned w;
    align_to(3);
    stage(32'hE4E4_E4E4, 4'hF, 8'd0);
    while (bc % 16 != 0) @(negedge clk);
    w = bc;
    for (int k = 0; k < 16; k++) begin
      if (k == 2) begin
        wait_arm = 1'b1; wait_target = w + 9;
      end else begin
        wait_arm = 1'b0;
      end
      // R8: only the wake pulse opens the enable
      chk("R8", "enable", 32'(eng_clk_en), 32'(k == 9));
      chk("R7", "wait_done", 32'(wait_done), 32'(k == 9));
      @(negedge clk);
      wait_arm = 1'b0;
    end
    cur_map = 32'hE4E4_E4E4; cur_off = 4'hF;
  endtask

  task automatic t_divider();
    int unsigned w;
    logic [31:0] m = 32'hE4E4_E4E4;
    logic [3:0]  o = 4'b0010;
    align_to(3);
    stage(m, o, 8'd2);
    while (bc % 16 != 0) @(negedge clk);
    w = bc;
    for (int k = 0; k < 48; k++) begin
      int  sl = (k / 3) % 16;
      logic tk = (k % 3 == 2);
      // R5 R9
      chk("R5", "task_id", 32'(task_id), 32'(own(m, sl)));
      chk("R9", "enable", 32'(eng_clk_en),
          32'((tk && !o[own(m, sl)]) || k == 12));
      chk("R9", "wait_done", 32'(wait_done), 32'(k == 12));
      if (k == 4) begin
        wait_arm = 1'b1; wait_target = w + 12;
      end
      if (k == 10) begin
        cfg_slot_map = '0; cfg_off_mask = '0; cfg_divider = '0; cfg_wr = 1'b1;
      end
      @(negedge clk);
      wait_arm = 1'b0; cfg_wr = 1'b0;
    end
    // R6: staged divider 0 takes over at the wrap
    for (int k = 0; k < 16; k++) begin
      chk("R6", "restored enable", 32'(eng_clk_en), 32'd1);
      chk("R6", "restored task", 32'(task_id), 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    t_reset();
    t_rate(32'hE4E4_E4E4, 4'b0101, 8);
    t_rate(32'hFFFF_FFFF & ~(32'h2 << 0) & ~(32'h2 << 10) & ~(32'h2 << 18), 4'b1000, 3);
    t_all_off();
    t_divider();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected done", bc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule